// File: doc/BRIEF.md
# Divisor Reciprocal Cache with Final Multiply

This block sits in front of a multiplication-based floating-point divider. It keeps a small fully associative store of divisor reciprocals. The key is the 52-bit divisor fraction alone. The dividend plays no part in the key, so any later divide by the same divisor can reuse a stored reciprocal whatever its dividend. Each request is looked up in the same cycle it is accepted. On a hit, the stored 56-bit reciprocal is read in one cycle. A two-stage pipelined multiplier then forms the quotient from the reciprocal and the dividend significand (hidden one restored).

On a miss, the block hands the divisor to an external reciprocal iteration engine in the accept cycle. It stalls new requests until the engine answers. It then writes the returned reciprocal into the store and sends it through the same final multiply. Square-root requests use the same engine and multiplier, with the multiplicand forced to 1.0. They never look in the store and never write to it, so they cannot displace reciprocals.

A victim is chosen at write time. The lowest-numbered invalid entry is taken first. Once every entry is valid, the victim comes from a free-running 16-bit LFSR.

Top module: `recip_cache_div`

## Requirements
- R1: After reset, res_valid_o is 0 and req_ready_o is 1. Every entry is invalid, so the first divide after reset misses whatever was stored before.
- R2: A divide (req_op_i = 0) whose divisor is stored raises no eng_start_o. Its result shows res_hit_o = 1 and appears exactly three cycles after the accept cycle.
- R3: A divide whose divisor is not stored raises eng_start_o in the accept cycle, with eng_mant_o equal to the divisor and eng_op_o = 0. Its result shows res_hit_o = 0 and appears two cycles after the cycle in which eng_done_i is high.
- R4: Once a miss has completed, a later divide by the same divisor hits.
- R5: res_data_o is the full 109-bit unrounded product of {1, dividend fraction} and the 56-bit reciprocal.
- R6: A square-root request (req_op_i = 1) always starts the engine with eng_op_o = 1. Its result shows res_op_o = 1 and res_hit_o = 0, even when the operand is stored as a divisor. Its res_data_o equals the engine result shifted left by 52. The request allocates nothing: stored divisors keep hitting, and a later divide by that operand still misses.
- R7: At most one miss is outstanding. req_ready_o is 0 from the cycle after eng_start_o through the cycle in which eng_done_i is seen, and 1 in the cycle after that.
- R8: While invalid entries remain, allocation never evicts a valid entry. After reset, ENTRIES distinct divisors all stay stored.
- R9: With every entry valid, a miss replaces one valid entry, and the newly written divisor hits on its next use.
- R10: Hits can be accepted in consecutive cycles, and their results appear in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted this cycle when high with req_valid_i |
| req_op_i | input | 1 | 0 divide, 1 square root |
| req_divisor_i | input | MANT_W | Divisor fraction (or square-root operand fraction) |
| req_dividend_i | input | MANT_W | Dividend fraction |
| eng_start_o | output | 1 | Start the reciprocal/root engine |
| eng_op_o | output | 1 | Engine function, encoded as req_op_i |
| eng_mant_o | output | MANT_W | Operand fraction for the engine |
| eng_done_i | input | 1 | Engine result valid (at least one cycle after start) |
| eng_result_i | input | RECIP_W | Engine result |
| res_valid_o | output | 1 | Result valid |
| res_hit_o | output | 1 | Result came from a stored reciprocal |
| res_op_o | output | 1 | Function of the result |
| res_data_o | output | MANT_W+RECIP_W+1 | Unrounded product |

## Verification
The hardest states to reach are replacement in a full store and the hand-off between a stream of hits and a following miss. In the second case, an engine answer one cycle after start sends a miss into the multiplier just behind a hit's read stage. The bench builds the bench instance with eight entries. It fills them with directed distinct divisors and re-reads all eight back to back, then forces an eviction with a ninth divisor. It then runs a random mix drawn from a pool of twelve divisors, with engine latency drawn from one to five cycles. This mix gives constant replacement, hit bursts, and the tightest miss timing.

// File: rtl/recip_cache_pkg.sv
`timescale 1ns/1ps
package recip_cache_pkg;
  typedef enum logic {OP_DIV = 1'b0, OP_SQRT = 1'b1} op_e;
  typedef struct packed {
    logic hit;
    op_e  op;
  } mul_tag_t;
endpackage

// File: rtl/recip_victim_sel.sv
`timescale 1ns/1ps
module recip_victim_sel #(
  parameter int ENTRIES = 128,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ENTRIES-1:0] valid_i,
  output logic [IDX_W-1:0]   idx_o
);
  localparam logic [15:0] TAPS = 16'hB400;

  logic [15:0]      lfsr_q;
  logic             free_found;
  logic [IDX_W-1:0] free_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lfsr_q <= 16'hACE1;
    else         lfsr_q <= {1'b0, lfsr_q[15:1]} ^ (lfsr_q[0] ? TAPS : 16'h0000);
  end

  // lowest invalid entry wins
  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
    end
  end

  assign idx_o = free_found ? free_idx : lfsr_q[IDX_W-1:0];
endmodule

// File: rtl/recip_cache_store.sv
`timescale 1ns/1ps
module recip_cache_store #(
  parameter int ENTRIES = 128,
  parameter int TAG_W   = 52,
  parameter int DATA_W  = 56,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [TAG_W-1:0]   lk_tag_i,
  output logic [ENTRIES-1:0] lk_hit_vec_o,
  output logic [DATA_W-1:0]  lk_data_o,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [TAG_W-1:0]   wr_tag_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  output logic [ENTRIES-1:0] valid_o
);
  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [DATA_W-1:0]  data_q [ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      valid_q <= '0;
    else if (wr_en_i) valid_q[wr_idx_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[wr_idx_i]  <= wr_tag_i;
      data_q[wr_idx_i] <= wr_data_i;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lk_hit_vec_o[g] = valid_q[g] && (tag_q[g] == lk_tag_i);
  end

  always_comb begin
    lk_data_o = '0;
    for (int i = 0; i < ENTRIES; i++)
      lk_data_o = lk_data_o | (data_q[i] & {DATA_W{lk_hit_vec_o[i]}});
  end

  assign valid_o = valid_q;
endmodule

// File: rtl/recip_mul_pipe.sv
`timescale 1ns/1ps
module recip_mul_pipe #(
  parameter int A_W   = 53,
  parameter int B_W   = 56,
  parameter int TAG_W = 2,
  localparam int LO_W = B_W / 2,
  localparam int HI_W = B_W - LO_W,
  localparam int P_W  = A_W + B_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic [A_W-1:0]   a_i,
  input  logic [B_W-1:0]   b_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             vld_o,
  output logic [P_W-1:0]   prod_o,
  output logic [TAG_W-1:0] tag_o
);
  logic                  s1_vld_q, s2_vld_q;
  logic [A_W+LO_W-1:0]   lo_q;
  logic [A_W+HI_W-1:0]   hi_q;
  logic [TAG_W-1:0]      s1_tag_q, s2_tag_q;
  logic [P_W-1:0]        prod_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld_q <= 1'b0;
      s2_vld_q <= 1'b0;
    end else begin
      s1_vld_q <= vld_i;
      s2_vld_q <= s1_vld_q;
    end
  end

  // stage 1: two half-width partial products, stage 2: aligned sum
  always_ff @(posedge clk_i) begin
    lo_q     <= {{LO_W{1'b0}}, a_i} * {{A_W{1'b0}}, b_i[LO_W-1:0]};
    hi_q     <= {{HI_W{1'b0}}, a_i} * {{A_W{1'b0}}, b_i[B_W-1:LO_W]};
    s1_tag_q <= tag_i;
    prod_q   <= P_W'(lo_q) + (P_W'(hi_q) << LO_W);
    s2_tag_q <= s1_tag_q;
  end

  assign vld_o  = s2_vld_q;
  assign prod_o = prod_q;
  assign tag_o  = s2_tag_q;
endmodule

// File: rtl/recip_cache_div.sv
`timescale 1ns/1ps
module recip_cache_div
  import recip_cache_pkg::*;
#(
  parameter int MANT_W  = 52,
  parameter int RECIP_W = 56,
  parameter int ENTRIES = 128
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_valid_i,
  output logic                      req_ready_o,
  input  logic                      req_op_i,
  input  logic [MANT_W-1:0]         req_divisor_i,
  input  logic [MANT_W-1:0]         req_dividend_i,
  output logic                      eng_start_o,
  output logic                      eng_op_o,
  output logic [MANT_W-1:0]         eng_mant_o,
  input  logic                      eng_done_i,
  input  logic [RECIP_W-1:0]        eng_result_i,
  output logic                      res_valid_o,
  output logic                      res_hit_o,
  output logic                      res_op_o,
  output logic [MANT_W+RECIP_W:0]   res_data_o
);
  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int OPA_W  = MANT_W + 1;
  localparam int TAG_W  = $bits(mul_tag_t);

  op_e                req_op;
  logic               accept, lk_hit, hit_take, miss_done, alloc;
  logic [ENTRIES-1:0] lk_hit_vec, valid_vec;
  logic [RECIP_W-1:0] lk_data;
  logic [IDX_W-1:0]   victim;

  logic               pend_q;
  op_e                pend_op_q;
  logic [MANT_W-1:0]  pend_mant_q, pend_dvd_q;

  logic               rd_vld_q;
  logic [MANT_W-1:0]  rd_dvd_q;
  logic [RECIP_W-1:0] rd_recip_q;

  logic               mul_vld;
  logic [OPA_W-1:0]   mul_a;
  logic [RECIP_W-1:0] mul_b;
  mul_tag_t           mul_tag, mul_tag_out;
  logic [TAG_W-1:0]   mul_tag_bits;

  assign req_op      = op_e'(req_op_i);
  assign req_ready_o = !pend_q;
  assign accept      = req_valid_i && !pend_q;
  assign lk_hit      = |lk_hit_vec;
  assign hit_take    = accept && (req_op == OP_DIV) && lk_hit;
  assign eng_start_o = accept && !hit_take;
  assign eng_op_o    = req_op_i;
  assign eng_mant_o  = req_divisor_i;
  assign miss_done   = pend_q && eng_done_i;
  assign alloc       = miss_done && (pend_op_q == OP_DIV);

  recip_cache_store #(
    .ENTRIES (ENTRIES),
    .TAG_W   (MANT_W),
    .DATA_W  (RECIP_W)
  ) u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .lk_tag_i     (req_divisor_i),
    .lk_hit_vec_o (lk_hit_vec),
    .lk_data_o    (lk_data),
    .wr_en_i      (alloc),
    .wr_idx_i     (victim),
    .wr_tag_i     (pend_mant_q),
    .wr_data_i    (eng_result_i),
    .valid_o      (valid_vec)
  );

  recip_victim_sel #(
    .ENTRIES (ENTRIES)
  ) u_victim (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_vec),
    .idx_o   (victim)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= 1'b0;
      rd_vld_q <= 1'b0;
    end else begin
      rd_vld_q <= hit_take;
      if (eng_start_o)     pend_q <= 1'b1;
      else if (eng_done_i) pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (eng_start_o) begin
      pend_op_q   <= req_op;
      pend_mant_q <= req_divisor_i;
      pend_dvd_q  <= req_dividend_i;
    end
    if (hit_take) begin
      rd_dvd_q   <= req_dividend_i;
      rd_recip_q <= lk_data;
    end
  end

  // hit read stage and miss completion never coincide: done comes at least a cycle after start
  always_comb begin
    mul_vld = rd_vld_q || miss_done;
    mul_a   = {1'b1, rd_dvd_q};
    mul_b   = rd_recip_q;
    mul_tag = '{hit: 1'b1, op: OP_DIV};
    if (!rd_vld_q) begin
      mul_a   = (pend_op_q == OP_SQRT) ? {1'b1, {MANT_W{1'b0}}} : {1'b1, pend_dvd_q};
      mul_b   = eng_result_i;
      mul_tag = '{hit: 1'b0, op: pend_op_q};
    end
  end

  recip_mul_pipe #(
    .A_W   (OPA_W),
    .B_W   (RECIP_W),
    .TAG_W (TAG_W)
  ) u_mul (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (mul_vld),
    .a_i    (mul_a),
    .b_i    (mul_b),
    .tag_i  (mul_tag),
    .vld_o  (res_valid_o),
    .prod_o (res_data_o),
    .tag_o  (mul_tag_bits)
  );

  assign mul_tag_out = mul_tag_t'(mul_tag_bits);
  assign res_hit_o   = mul_tag_out.hit;
  assign res_op_o    = mul_tag_out.op;
endmodule

// File: rtl/recip_cache_div_chk.sv
`timescale 1ns/1ps
module recip_cache_div_chk #(
  parameter int ENTRIES = 128
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_valid_i,
  input logic               req_ready_o,
  input logic               req_op_i,
  input logic               eng_start_o,
  input logic               eng_op_o,
  input logic               eng_done_i,
  input logic               res_valid_o,
  input logic               res_hit_o,
  input logic               res_op_o,
  input logic [ENTRIES-1:0] lk_hit_vec_i
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_idle_r1: assert (!res_valid_o && req_ready_o);
    end
  end

  p_hit_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && !req_op_i && !eng_start_o) |-> ##3 (res_valid_o && res_hit_o));

  p_miss_latency_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_done_i && !req_ready_o) |-> ##2 (res_valid_o && !res_hit_o));

  p_unique_tag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lk_hit_vec_i));

  p_sqrt_to_engine_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_op_i) |-> (eng_start_o && eng_op_o));

  p_sqrt_no_hit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_op_o) |-> !res_hit_o);

  p_stall_after_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |=> !req_ready_o);

  p_release_after_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_done_i && !req_ready_o) |=> req_ready_o);
endmodule

bind recip_cache_div recip_cache_div_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .req_op_i     (req_op_i),
  .eng_start_o  (eng_start_o),
  .eng_op_o     (eng_op_o),
  .eng_done_i   (eng_done_i),
  .res_valid_o  (res_valid_o),
  .res_hit_o    (res_hit_o),
  .res_op_o     (res_op_o),
  .lk_hit_vec_i (lk_hit_vec)
);

// File: tb/recip_cache_div_bench.sv
`timescale 1ns/1ps
module recip_cache_div_bench;
  localparam int MW = 52;
  localparam int RW = 56;
  localparam int PW = MW + RW + 1;
  localparam int NE = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid_i = 1'b0;
  logic          req_ready_o;
  logic          req_op_i = 1'b0;
  logic [MW-1:0] req_divisor_i = '0;
  logic [MW-1:0] req_dividend_i = '0;
  logic          eng_start_o, eng_op_o;
  logic [MW-1:0] eng_mant_o;
  logic          eng_done_i = 1'b0;
  logic [RW-1:0] eng_result_i = '0;
  logic          res_valid_o, res_hit_o, res_op_o;
  logic [PW-1:0] res_data_o;

  recip_cache_div #(.MANT_W(MW), .RECIP_W(RW), .ENTRIES(NE)) u_recip_cache_div (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_op_i, .req_divisor_i,
    .req_dividend_i, .eng_start_o, .eng_op_o, .eng_mant_o, .eng_done_i,
    .eng_result_i, .res_valid_o, .res_hit_o, .res_op_o, .res_data_o
  );

  always #5 clk_i = ~clk_i;

  typedef struct {
    logic          op;
    logic [PW-1:0] exp;
    int            want;
    int            acc;
    int            done;
    bit            started;
    string         tag;
  } exp_t;

  exp_t    sb[$];
  exp_t    ev;
  int      n_chk = 0, n_bad = 0, cyc = 0;
  bit      b_pend = 0, rel_chk = 0, st_seen = 0, e_busy = 0, finished = 0;
  logic    st_op, e_op;
  logic [MW-1:0] st_mant, e_mant;
  int      e_cnt = 0;
  int      cur_want = -1;
  string   cur_tag = "R5";
  logic [MW-1:0] pool [12];

  function automatic logic [RW-1:0] stub(input logic op, input logic [MW-1:0] m);
    return {(op ? 4'h9 : 4'h5), m ^ 52'h5_A5A5_1234_5678};
  endfunction

  function automatic logic [PW-1:0] exp_q(input logic op, input logic [MW-1:0] dd,
                                          input logic [RW-1:0] rc);
    logic [PW-1:0] a, b;
    a = {{RW{1'b0}}, 1'b1, (op ? {MW{1'b0}} : dd)};
    b = {{(MW+1){1'b0}}, rc};
    return a * b;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
    end
  endtask

  // monitor: samples at negedge, inputs change just after posedge
  always @(negedge clk_i) begin
    cyc++;
    st_seen = 1'b0;
    if (rst_ni) begin
      if (rel_chk) begin
        chk(req_ready_o == 1'b1, "R7", "ready after writeback", 128'(req_ready_o), 128'd1);
        rel_chk = 0;
      end
      if (b_pend) chk(!req_ready_o, "R7", "ready while miss pending", 128'(req_ready_o), 128'd0);
      if (res_valid_o) begin
        if (sb.size() == 0) begin
          chk(0, "R5", "unexpected result", 128'd1, 128'd0);
        end else begin
          ev = sb.pop_front();
          chk(res_data_o == ev.exp, ev.op ? "R6" : "R5", "result data", 128'(res_data_o), 128'(ev.exp));
          chk(res_op_o == ev.op, "R6", "result op", 128'(res_op_o), 128'(ev.op));
          if (ev.want >= 0)
            chk(res_hit_o == ev.want[0], ev.tag, "hit flag", 128'(res_hit_o), 128'(ev.want));
          if (res_hit_o) begin
            chk(cyc == ev.acc + 3, {"R2 ", ev.tag}, "hit latency", 128'(cyc), 128'(ev.acc + 3));
            chk(!ev.started, "R2", "engine started on hit", 128'(ev.started), 128'd0);
          end else begin
            chk(ev.started && cyc == ev.done + 2, {"R3 ", ev.tag}, "miss latency",
                128'(cyc), 128'(ev.done + 2));
          end
        end
      end
      if (eng_done_i && b_pend) begin
        sb[sb.size()-1].done = cyc;
        b_pend  = 0;
        rel_chk = 1;
      end
      if (req_valid_i && req_ready_o) begin
        ev.op      = req_op_i;
        ev.exp     = exp_q(req_op_i, req_dividend_i, stub(req_op_i, req_divisor_i));
        ev.want    = cur_want;
        ev.acc     = cyc;
        ev.done    = -100;
        ev.started = eng_start_o;
        ev.tag     = cur_tag;
        if (req_op_i)
          chk(eng_start_o == 1'b1, "R6", "square root must start engine", 128'(eng_start_o), 128'd1);
        if (eng_start_o) begin
          b_pend  = 1;
          st_seen = 1'b1;
          st_op   = eng_op_o;
          st_mant = eng_mant_o;
          chk(eng_mant_o == req_divisor_i && eng_op_o == req_op_i, "R3", "engine operand",
              128'({eng_op_o, eng_mant_o}), 128'({req_op_i, req_divisor_i}));
        end
        sb.push_back(ev);
      end
    end
  end

  // engine stub: latency 1..5 cycles
  always @(posedge clk_i) begin
    #1;
    eng_done_i = 1'b0;
    if (!rst_ni) begin
      e_busy = 0;
    end else begin
      if (st_seen) begin
        e_busy = 1; e_cnt = 1 + int'($urandom() % 5); e_op = st_op; e_mant = st_mant;
      end
      if (e_busy) begin
        e_cnt--;
        if (e_cnt == 0) begin
          eng_done_i   = 1'b1;
          eng_result_i = stub(e_op, e_mant);
          e_busy       = 0;
        end
      end
    end
  end

  always @(negedge clk_i) begin
    if (cyc > 150000 && !finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic send(input logic op, input logic [MW-1:0] dv, input logic [MW-1:0] dd,
                      input int want, input string tag);
    @(posedge clk_i); #1;
    req_valid_i = 1'b1; req_op_i = op; req_divisor_i = dv; req_dividend_i = dd;
    cur_want = want; cur_tag = tag;
    do @(negedge clk_i); while (!req_ready_o);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i); #1;
      req_valid_i = 1'b0;
    end
  endtask

  task automatic drain();
    idle(1);
    while (sb.size() != 0 || b_pend) @(negedge clk_i);
    idle(2);
  endtask

  task automatic do_reset();
    @(posedge clk_i); #1;
    rst_ni = 1'b0; req_valid_i = 1'b0;
    b_pend = 0; rel_chk = 0;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!res_valid_o && req_ready_o && !eng_start_o, "R1", "idle after reset",
        128'({res_valid_o, req_ready_o, eng_start_o}), 128'(3'b010));
  endtask

  logic [MW-1:0] d1, s2, d9;

  initial begin
    void'($urandom(32'd20250));
    for (int i = 0; i < 12; i++) pool[i] = {20'($urandom()), 32'($urandom())};
    d1 = 52'h8_0000_0000_0001;
    s2 = 52'h3_3333_CCCC_0F0F;
    d9 = 52'hF_EDCB_A987_6543;

    do_reset();

    // directed: miss, allocate, hit, square root isolation
    send(1'b0, d1, 52'h1_2345_6789_ABCD, 0, "R3");
    drain();
    send(1'b0, d1, 52'hF_FFFF_FFFF_FFFF, 1, "R4");
    drain();
    send(1'b1, d1, 52'h0_1111_2222_3333, 0, "R6");
    drain();
    send(1'b0, d1, 52'd0, 1, "R6");
    send(1'b1, s2, 52'h7, 0, "R6");
    drain();
    send(1'b1, s2, 52'h9, 0, "R6");
    drain();
    send(1'b0, s2, 52'hA_BCDE_0000_1234, 0, "R6");
    drain();

    // reset clears all entries
    do_reset();
    send(1'b0, d1, 52'h5, 0, "R1");
    drain();

    // fill every entry, then re-read back to back
    for (int i = 1; i < NE; i++) begin
      send(1'b0, pool[i], {20'($urandom()), 32'($urandom())}, 0, "R8");
      drain();
    end
    send(1'b0, d1, 52'h42, 1, "R8");
    for (int i = 1; i < NE; i++)
      send(1'b0, pool[i], {20'($urandom()), 32'($urandom())}, 1, "R10");
    drain();

    // full store: new divisor evicts one and then hits
    send(1'b0, d9, 52'h0_0F0F_F0F0_0F0F, 0, "R9");
    drain();
    send(1'b0, d9, 52'h1, 1, "R9");
    drain();

    // random mix over a small pool
    for (int k = 0; k < 300; k++) begin
      send(1'(($urandom() % 100) < 15), pool[$urandom() % 12],
           {20'($urandom()), 32'($urandom())}, -1, "R5");
      if ($urandom() % 4 == 0) idle(1 + int'($urandom() % 3));
    end
    drain();

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule